// File: doc/BRIEF.md
# Dual-Channel Serial Code Loader

This block is the digital front end of a two-channel converter. A host drives a synchronous serial stream into it over four wires: a serial clock, a data line, an active-low select and an active-low load strobe. The block collects each frame in a 14-bit shift register and keeps two 12-bit output codes, one per channel. Each code drives the analog stage, which lies outside this block.

A frame has 14 bits. Two address bits come first and twelve code bits follow, most significant bit first. All four serial wires are asynchronous to the system clock. Each passes through a two-flop synchronizer, and a rising serial clock edge is found from the synchronized samples, so the whole block runs on the one fast system clock.

The output registers act as level-transparent latches under the load strobe. While the strobe is low they follow the shift register, and the two oldest bits of the shift register choose which channel or channels are written. While the strobe is high they hold. The host therefore shifts a frame in with the strobe high and then pulses the strobe low. If bits are shifted while the strobe is low, the chosen outputs change with every bit.

Top module: `dual_code_loader`

## Requirements
- R1: A synchronous active-high reset clears the shift register and both output codes to 000h.
- R2: Each rising edge of the serial clock seen while select is low shifts the data bit into the shift register at its least significant end. After 14 such edges the first bit sent (A1) is at bit 13, A0 is at bit 12 and the code bits D11..D0 are at bits 11..0.
- R3: While select is high, serial clock edges do not shift, and the shift register keeps its contents.
- R4: While the load strobe is high, both output codes hold their values whatever happens on the other serial inputs.
- R5: While the load strobe is low, each selected output code takes shift register bits 11..0 one system clock after the synchronized values, regardless of select or serial clock.
- R6: Address decoding uses shift register bits 13 (A1) and 12 (A0). A1=0 writes both channels whatever A0 is. A1=1 with A0=0 writes channel A only. A1=1 with A0=1 writes channel B only.
- R7: Bits shifted while the load strobe is low change the selected outputs after each bit, with the address taken from the updated shift register.
- R8: Output codes are straight binary and pass unchanged over the whole range from 000h (zero scale) to FFFh (full scale).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous; shifts on its rising edge |
| sdi_i | input | 1 | Serial data, asynchronous |
| sel_n_i | input | 1 | Active-low select, enables shifting |
| load_n_i | input | 1 | Active-low load strobe, makes the output registers transparent |
| code_a_o | output | 12 | Channel A output code |
| code_b_o | output | 12 | Channel B output code |

## Verification
The shift register cannot be seen directly. A fault in it, such as a lost or extra shift, a wrong bit order, or a shift while select is high, shows up at the ports at the next load pulse, about four system clocks after the strobe falls: the wrong channel is written, or a code appears rotated. A decode fault shows up at once as a write to the wrong channel. The bench therefore walks frames that differ in address and in code, and checks both channels after each one. The extra-bit shift while the strobe is low exposes ordering faults within a single serial period, because the address itself changes under the open latch.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    TGT_BOTH = 2'd0,
    TGT_A    = 2'd1,
    TGT_B    = 2'd2
  } target_e;

  // A1 clear selects both channels; with A1 set, A0 picks B over A.
  function automatic target_e decode_target(input logic a1, input logic a0);
    if (!a1)     return TGT_BOTH;
    else if (a0) return TGT_B;
    else         return TGT_A;
  endfunction
endpackage

// File: rtl/dcl_sync.sv
module dcl_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dcl_shifter.sv
module dcl_shifter #(
  parameter int FRAME_W = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               sdi_s,
  input  logic               sel_n_s,
  output logic [FRAME_W-1:0] frame_o
);
  logic sclk_d;
  logic step;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign step = sclk_s && !sclk_d && !sel_n_s;

  always_ff @(posedge clk) begin
    if (rst)       frame_o <= '0;
    else if (step) frame_o <= {frame_o[FRAME_W-2:0], sdi_s};
  end

  // R3
  no_shift_chk: assert property (@(posedge clk) disable iff (rst)
    sel_n_s |=> $stable(frame_o));

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_s && !sclk_d && !sel_n_s) |=>
      (frame_o[0] == $past(sdi_s) && frame_o[FRAME_W-1:1] == $past(frame_o[FRAME_W-2:0])));
endmodule

// File: rtl/dcl_outregs.sv
module dcl_outregs
  import dcl_pkg::*;
#(
  parameter int CODE_W  = 12,
  parameter int FRAME_W = CODE_W + ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_n_s,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [CODE_W-1:0]  code_a_o,
  output logic [CODE_W-1:0]  code_b_o
);
  target_e tgt;
  logic    wr_a, wr_b;

  assign tgt  = decode_target(frame_i[FRAME_W-1], frame_i[FRAME_W-2]);
  assign wr_a = !load_n_s && (tgt != TGT_B);
  assign wr_b = !load_n_s && (tgt != TGT_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_a_o <= '0;
      code_b_o <= '0;
    end else begin
      if (wr_a) code_a_o <= frame_i[CODE_W-1:0];
      if (wr_b) code_b_o <= frame_i[CODE_W-1:0];
    end
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    load_n_s |=> ($stable(code_a_o) && $stable(code_b_o)));

  // R6
  only_a_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_n_s && frame_i[FRAME_W-1 -: 2] == 2'b10) |=> $stable(code_b_o));

  // R6
  only_b_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_n_s && frame_i[FRAME_W-1 -: 2] == 2'b11) |=> $stable(code_a_o));

  // R5
  both_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_n_s && !frame_i[FRAME_W-1]) |=>
      (code_a_o == code_b_o && code_a_o == $past(frame_i[CODE_W-1:0])));
endmodule

// File: rtl/dual_code_loader.sv
module dual_code_loader
  import dcl_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              sel_n_i,
  input  logic              load_n_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o
);
  localparam int FRAME_W = CODE_W + ADDR_W;

  logic [3:0]         raw, synced;
  logic [FRAME_W-1:0] frame;

  assign raw = {load_n_i, sel_n_i, sdi_i, sclk_i};

  dcl_sync #(
    .W       (4),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b1100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw),
    .q_o (synced)
  );

  dcl_shifter #(
    .FRAME_W (FRAME_W)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .sclk_s  (synced[0]),
    .sdi_s   (synced[1]),
    .sel_n_s (synced[2]),
    .frame_o (frame)
  );

  dcl_outregs #(
    .CODE_W  (CODE_W),
    .FRAME_W (FRAME_W)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .load_n_s (synced[3]),
    .frame_i  (frame),
    .code_a_o (code_a_o),
    .code_b_o (code_b_o)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (code_a_o == '0 && code_b_o == '0));
endmodule

// File: tb/dual_code_loader_bench.sv
module dual_code_loader_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdi = 1'b0, sel_n = 1'b1, load_n = 1'b1;
  logic [11:0] code_a, code_b;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_code_loader u_dual_code_loader (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdi_i(sdi),
    .sel_n_i(sel_n), .load_n_i(load_n),
    .code_a_o(code_a), .code_b_o(code_b)
  );

  // {addr[1:0], code[11:0], expected A, expected B}
  localparam int NV = 6;
  localparam logic [37:0] VEC [NV] = '{
    {2'b00, 12'hABC, 12'hABC, 12'hABC},
    {2'b10, 12'h123, 12'h123, 12'hABC},
    {2'b11, 12'hFFF, 12'h123, 12'hFFF},
    {2'b01, 12'h000, 12'h000, 12'h000},
    {2'b10, 12'h800, 12'h800, 12'h000},
    {2'b11, 12'h7FF, 12'h800, 12'h7FF}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b; sclk = 1'b0; wait_clk(4);
    sclk = 1'b1; wait_clk(4);
    sclk = 1'b0;
  endtask

  task automatic send_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) send_bit(f[i]);
    wait_clk(4);
  endtask

  task automatic pulse_load;
    load_n = 1'b0; wait_clk(6);
    load_n = 1'b1; wait_clk(6);
  endtask

  task automatic check(input string req, input logic [11:0] ea, input logic [11:0] eb);
    checks++;
    if (code_a !== ea || code_b !== eb) begin
      errors++;
      $display("FAIL %s: A=%h B=%h expected A=%h B=%h", req, code_a, code_b, ea, eb);
    end
  endtask

  initial begin
    wait_clk(4);
    // R1 reset state
    check("R1", 12'h000, 12'h000);
    rst = 1'b0;
    wait_clk(4);
    check("R1", 12'h000, 12'h000);

    // R2 R6 R8: table of frames, each loaded with a strobe pulse
    sel_n = 1'b0;
    for (int v = 0; v < NV; v++) begin
      send_frame(VEC[v][37:24]);
      pulse_load();
      check("R2/R6/R8", VEC[v][23:12], VEC[v][11:0]);
    end

    // R4: a new frame shifted with the strobe high leaves the outputs alone
    send_frame({2'b00, 12'h5A5});
    check("R4", 12'h800, 12'h7FF);

    // R3: restore {11,7FF}, then shift with select high; the load must still see {11,7FF}
    send_frame({2'b11, 12'h7FF});
    sel_n = 1'b1;
    send_frame({2'b10, 12'h555});
    pulse_load();
    check("R3", 12'h800, 12'h7FF);

    // R5: strobe low, full frame for A; A follows without a strobe release
    sel_n = 1'b0;
    load_n = 1'b0;
    send_frame({2'b10, 12'h3C5});
    checks++;
    if (code_a !== 12'h3C5) begin
      errors++;
      $display("FAIL R5: A=%h expected A=%h", code_a, 12'h3C5);
    end
    // R7: one more bit; frame becomes 00_0111_1000_1011 and both follow
    send_bit(1'b1);
    wait_clk(4);
    check("R7", 12'h78B, 12'h78B);
    load_n = 1'b1;
    wait_clk(6);

    // R4: strobe high, more bits; outputs hold
    send_frame({2'b00, 12'hFFF});
    check("R4", 12'h78B, 12'h78B);

    // R8: full scale to both channels
    pulse_load();
    check("R8", 12'hFFF, 12'hFFF);

    // R1: reset in mid-run
    rst = 1'b1; wait_clk(2);
    check("R1", 12'h000, 12'h000);
    rst = 1'b0; wait_clk(2);
    pulse_load();
    check("R1", 12'h000, 12'h000);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule